// File: doc/BRIEF.md
# Interrupt Output Pin Controller

This block folds a vector of interrupt request flags into one interrupt pin for a serial-bus host. The host picks one of two signalling styles. In level style the pin is an active-low open-drain line. In edge style the pin is a push-pull line that gives a fixed-width pulse, either falling or rising, whenever host attention is needed. A global enable gates the whole pin. The idle level of the pin depends on the chosen style and polarity.

Open-drain behaviour is modelled by two outputs. `pin_oe` is the drive enable. `pin_out` is the value driven while the enable is high. The pending flags and the per-flag set and clear events come from the interrupt register logic around this block. The block only watches them and never stores them. All inputs are sampled on the rising clock edge, and both outputs are registered, so every response appears one clock after the input that causes it.

Top module: `irq_pin_ctrl`

## Requirements
- R1: While `irq_en` is 0, the pin shows the idle level of the selected style one cycle later, whatever flags or events are present. Dropping `irq_en` during a pulse ends that pulse.
- R2: Idle levels are as follows. Level style (`level_mode`=1) gives `pin_oe`=0 and `pin_out`=0, so the pin is released. Edge style with `pos_pol`=0 gives `pin_oe`=1 and `pin_out`=1. Edge style with `pos_pol`=1 gives `pin_oe`=1 and `pin_out`=0.
- R3: In level style with `irq_en`=1, `pin_oe` is 1 and `pin_out` is 0 in the cycle after any bit of `flags` is 1. The pin is released in the cycle after all flags are 0.
- R4: In level style, `pos_pol`, `set_evt` and `clr_evt` do not affect the pin.
- R5: In edge style with `irq_en`=1, `pin_oe` is always 1.
- R6: In edge style, a cycle in which any bit of `set_evt` is 1 starts a pulse in the next cycle. During a pulse `pin_out` equals `pos_pol`; otherwise it equals `!pos_pol`.
- R7: In edge style, a cycle with a `clr_evt` bit set also starts a pulse if `flags & ~clr_evt` is nonzero. Clearing the last pending flag starts no pulse.
- R8: A pulse lasts exactly `PULSE_CYC` cycles (default 128, which is about 10.67 us at 12 MHz).
- R9: A trigger that arrives while a pulse is running restarts it, so the pin stays active until `PULSE_CYC` cycles after the last trigger.
- R10: A cycle with `rst`=1 makes both outputs 0 in the next cycle and cancels any pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en | input | 1 | Global pin enable |
| level_mode | input | 1 | 1 = open-drain level style, 0 = push-pull pulse style |
| pos_pol | input | 1 | Pulse polarity in edge style: 1 = rising pulse, 0 = falling pulse |
| flags | input | NUM_IRQ | Pending interrupt request flags |
| set_evt | input | NUM_IRQ | One-cycle strobes: a request becomes active |
| clr_evt | input | NUM_IRQ | One-cycle strobes: a request is cleared |
| pin_oe | output | 1 | Pin drive enable |
| pin_out | output | 1 | Pin drive value |

## Verification
Two functions can meet in the same cycle. A trigger can arrive in the final cycle of a running pulse, where restarting the pulse competes with letting it expire. An enable drop can coincide with a trigger. The bench places a retrigger exactly one cycle before expiry and checks that the pin stays active without a gap for one full width past that trigger. It also drops the enable together with a set event and expects the idle level, not a new pulse. Random stimulus mixes set and clear strobes with mode changes, and a cycle-by-cycle model checks the result.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
  typedef struct packed {
    logic oe;
    logic val;
  } pin_drv_t;

  localparam pin_drv_t PIN_RELEASED = '{oe: 1'b0, val: 1'b0};

  function automatic pin_drv_t idle_drive(input logic level_mode, input logic pos_pol);
    pin_drv_t d;
    if (level_mode) d = PIN_RELEASED;
    else            d = '{oe: 1'b1, val: ~pos_pol};
    return d;
  endfunction
endpackage

// File: rtl/irq_trig_detect.sv
module irq_trig_detect #(
  parameter int NUM_IRQ = 8
) (
  input  logic               run,
  input  logic [NUM_IRQ-1:0] flags,
  input  logic [NUM_IRQ-1:0] set_evt,
  input  logic [NUM_IRQ-1:0] clr_evt,
  output logic               trig
);
  logic [NUM_IRQ-1:0] left_pending;
  logic               any_set;
  logic               any_clr;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_left
    assign left_pending[i] = flags[i] & ~clr_evt[i];
  end

  always_comb begin
    any_set = |set_evt;
    any_clr = |clr_evt;
    trig    = run & (any_set | (any_clr & (|left_pending)));
  end
endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
  parameter int PULSE_CYC = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic trig,
  output logic active_next
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (!run)                cnt_d = '0;
    else if (trig)           cnt_d = LOAD;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    else                     cnt_d = '0;
    active_next = (cnt_d != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
  import irq_pin_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic irq_en,
  input  logic level_mode,
  input  logic pos_pol,
  input  logic any_pend,
  input  logic pulse_on,
  output logic pin_oe,
  output logic pin_out
);
  pin_drv_t drv_d;
  pin_drv_t drv_q;

  always_comb begin
    if (!irq_en)         drv_d = idle_drive(level_mode, pos_pol);
    else if (level_mode) drv_d = '{oe: any_pend, val: 1'b0};
    else                 drv_d = '{oe: 1'b1, val: pulse_on ? pos_pol : ~pos_pol};
  end

  always_ff @(posedge clk) begin
    if (rst) drv_q <= PIN_RELEASED;
    else     drv_q <= drv_d;
  end

  assign pin_oe  = drv_q.oe;
  assign pin_out = drv_q.val;
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl #(
  parameter int NUM_IRQ   = 8,
  parameter int PULSE_CYC = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               irq_en,
  input  logic               level_mode,
  input  logic               pos_pol,
  input  logic [NUM_IRQ-1:0] flags,
  input  logic [NUM_IRQ-1:0] set_evt,
  input  logic [NUM_IRQ-1:0] clr_evt,
  output logic               pin_oe,
  output logic               pin_out
);
  logic edge_run;
  logic trig;
  logic pulse_on;

  assign edge_run = irq_en & ~level_mode;

  irq_trig_detect #(.NUM_IRQ(NUM_IRQ)) trig_i (
    .run     (edge_run),
    .flags   (flags),
    .set_evt (set_evt),
    .clr_evt (clr_evt),
    .trig    (trig)
  );

  irq_pulse_timer #(.PULSE_CYC(PULSE_CYC)) timer_i (
    .clk         (clk),
    .rst         (rst),
    .run         (edge_run),
    .trig        (trig),
    .active_next (pulse_on)
  );

  irq_pin_drive drive_i (
    .clk        (clk),
    .rst        (rst),
    .irq_en     (irq_en),
    .level_mode (level_mode),
    .pos_pol    (pos_pol),
    .any_pend   (|flags),
    .pulse_on   (pulse_on),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out)
  );
endmodule

// File: rtl/irq_pin_ctrl_chk.sv
module irq_pin_ctrl_chk #(
  parameter int NUM_IRQ = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               irq_en,
  input logic               level_mode,
  input logic               pos_pol,
  input logic [NUM_IRQ-1:0] flags,
  input logic [NUM_IRQ-1:0] set_evt,
  input logic [NUM_IRQ-1:0] clr_evt,
  input logic               pin_oe,
  input logic               pin_out
);
  AST_RESET_RELEASE: assert property (@(posedge clk)
    rst |=> (!pin_oe && !pin_out)); // R10

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> ($past(level_mode) ? (!pin_oe && !pin_out)
                                   : (pin_oe && pin_out == !$past(pos_pol)))); // R1

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (irq_en && level_mode) |=> (pin_oe == $past(|flags) && !pin_out)); // R3

  AST_EDGE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (irq_en && !level_mode) |=> pin_oe); // R5

  AST_SET_PULSE: assert property (@(posedge clk) disable iff (rst)
    (irq_en && !level_mode && |set_evt) |=> (pin_out == $past(pos_pol))); // R6

  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (rst)
    (irq_en && !level_mode && |clr_evt && |(flags & ~clr_evt))
      |=> (pin_out == $past(pos_pol))); // R7
endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .irq_en     (irq_en),
  .level_mode (level_mode),
  .pos_pol    (pos_pol),
  .flags      (flags),
  .set_evt    (set_evt),
  .clr_evt    (clr_evt),
  .pin_oe     (pin_oe),
  .pin_out    (pin_out)
);

// File: tb/irq_pin_ctrl_tb_top.sv
module irq_pin_ctrl_tb_top;
  localparam int N  = 8;
  localparam int PW = 128;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         irq_en = 1'b0;
  logic         level_mode = 1'b0;
  logic         pos_pol = 1'b0;
  logic [N-1:0] flags = '0;
  logic [N-1:0] set_evt = '0;
  logic [N-1:0] clr_evt = '0;
  logic         pin_oe;
  logic         pin_out;

  int    total = 0;
  int    bad = 0;
  string cur_tag = "R10";

  int m_cnt = 0;
  bit m_oe = 0;
  bit m_out = 0;

  always #2 clk = ~clk;

  irq_pin_ctrl #(.NUM_IRQ(N), .PULSE_CYC(PW)) dut_i (
    .clk(clk), .rst(rst), .irq_en(irq_en), .level_mode(level_mode),
    .pos_pol(pos_pol), .flags(flags), .set_evt(set_evt), .clr_evt(clr_evt),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );

  function automatic bit is_trig();
    return irq_en && !level_mode &&
           ((|set_evt) || ((|clr_evt) && (|(flags & ~clr_evt))));
  endfunction

  task automatic model_edge();
    if (rst) begin
      m_cnt = 0; m_oe = 0; m_out = 0;
    end else begin
      if (!irq_en || level_mode) m_cnt = 0;
      else if (is_trig())        m_cnt = PW;
      else if (m_cnt > 0)        m_cnt = m_cnt - 1;
      if (!irq_en) begin
        m_oe = !level_mode; m_out = level_mode ? 1'b0 : !pos_pol;
      end else if (level_mode) begin
        m_oe = |flags; m_out = 0;
      end else begin
        m_oe = 1; m_out = (m_cnt != 0) ? pos_pol : !pos_pol;
      end
    end
  endtask

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(pin_oe == m_oe, cur_tag, "pin_oe", pin_oe, m_oe);
    chk(pin_out == m_out, cur_tag, "pin_out", pin_out, m_out);
    flags   = (flags | set_evt) & ~clr_evt;
    set_evt = '0;
    clr_evt = '0;
  endtask

  task automatic count_active(int n, output int act);
    act = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (pin_out == pos_pol) act++;
    end
  endtask

  initial begin
    int act;
    int a2;
    void'($urandom(32'd4242));
    @(negedge clk);
    cur_tag = "R10";
    flags = 8'h0f; irq_en = 1; level_mode = 1;
    step(); step();
    chk(pin_oe == 0 && pin_out == 0, "R10", "reset pin", {pin_oe, pin_out}, 0);
    rst = 0;

    cur_tag = "R2";
    irq_en = 0; flags = 8'hff;
    level_mode = 1; step();
    chk(pin_oe == 0, "R2", "level idle oe", pin_oe, 0);
    level_mode = 0; pos_pol = 0; step();
    chk(pin_oe == 1 && pin_out == 1, "R2", "neg idle", {pin_oe, pin_out}, 3);
    pos_pol = 1; set_evt = 8'h01; step();
    chk(pin_oe == 1 && pin_out == 0, "R1", "pos idle with event", {pin_oe, pin_out}, 2);

    cur_tag = "R3";
    irq_en = 1; level_mode = 1; flags = 8'h00; step();
    chk(pin_oe == 0, "R3", "no pending released", pin_oe, 0);
    flags = 8'h24; step();
    chk(pin_oe == 1 && pin_out == 0, "R3", "pending drives low", {pin_oe, pin_out}, 2);
    clr_evt = 8'h04; step();
    chk(pin_oe == 1, "R3", "one left still low", pin_oe, 1);
    cur_tag = "R4";
    pos_pol = 0; set_evt = 8'h80; step();
    pos_pol = 1; step();
    chk(pin_oe == 1 && pin_out == 0, "R4", "polarity ignored", {pin_oe, pin_out}, 2);
    flags = 8'h00; step();
    chk(pin_oe == 0, "R3", "last clear releases", pin_oe, 0);

    cur_tag = "R8";
    level_mode = 0; pos_pol = 1; step();
    chk(pin_oe == 1, "R5", "edge drives", pin_oe, 1);
    set_evt = 8'h02; count_active(PW + 40, act);
    chk(act == PW, "R8", "rising pulse width", act, PW);
    pos_pol = 0; step();
    set_evt = 8'h40; count_active(PW + 40, act);
    chk(act == PW, "R6", "falling pulse width", act, PW);

    cur_tag = "R7";
    flags = 8'h03; clr_evt = 8'h01; count_active(PW + 20, act);
    chk(act == PW, "R7", "clear with other pending", act, PW);
    clr_evt = 8'h02; count_active(PW + 20, act);
    chk(act == 0, "R7", "clear of last pending", act, 0);

    cur_tag = "R9";
    set_evt = 8'h01; count_active(PW - 1, act);
    set_evt = 8'h08; count_active(PW + 40, a2);
    chk(act + a2 == 2 * PW - 1, "R9", "retrigger at last cycle", act + a2, 2 * PW - 1);

    cur_tag = "R1";
    flags = 8'h00;
    set_evt = 8'h01; count_active(10, act);
    irq_en = 0; set_evt = 8'h10; step();
    chk(pin_out == 1, "R1", "enable drop ends pulse", pin_out, 1);
    irq_en = 1; count_active(PW, act);
    chk(act == 0, "R1", "no pulse resumes", act, 0);

    cur_tag = "R2/R3/R5/R6/R7";
    for (int c = 0; c < 6000; c++) begin
      if (c % 250 == 0) begin
        irq_en = ($urandom % 5) != 0;
        level_mode = $urandom % 2;
        pos_pol = $urandom % 2;
      end
      if ($urandom % 90 == 0) set_evt = N'(1) << ($urandom % N);
      if ($urandom % 70 == 0) clr_evt = flags & (N'(1) << ($urandom % N));
      step();
    end

    cur_tag = "R10";
    irq_en = 1; level_mode = 0; set_evt = 8'h01; step();
    rst = 1; step();
    chk(pin_oe == 0 && pin_out == 0, "R10", "reset mid pulse", {pin_oe, pin_out}, 0);
    rst = 0; pos_pol = 0; step();
    chk(pin_out == 1, "R10", "pulse cancelled", pin_out, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule